// File: doc/BRIEF.md
# Data-strobe serial token transmitter with rate ladder

The block turns a stream of data bytes and link control codes into a serial token stream on two wires. The data wire carries each bit's value. The strobe wire changes state in every bit period where the data wire does not. A data token is ten bits long and a control token is four. Every token opens with its parity bit, which makes parity checkable on each token at the far end. When no token is offered, the block fills the line with Null tokens, so the link never goes quiet. The transmit path needs nothing from any receive logic.

A divider sets the bit rate. It counts cycles of a 200 MHz clock, so one bit leaves every N cycles. The divider holds 20 (10 Mbit/s) from reset until software writes another value. The usual settings are 1, 20, 40, 80 and 160, and any value in between also works. A new divider takes effect at the next token boundary. With power-save enabled, each Null token goes out at the reset-default rate. Data and non-Null control tokens keep the programmed rate.

Top module: `dslink_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, both `link_d` and `link_s` are 0. Until the first write, every bit lasts 20 clock cycles.
- R2: In each clock cycle, at most one of `link_d` and `link_s` changes. At every bit boundary exactly one changes: `link_d` takes the new bit, and `link_s` toggles when that bit equals the previous bit.
- R3: A data token goes out as parity, then a flag of 0, then the 8 data bits, least significant first. Accepted data tokens appear on the line in the order they were accepted, with their values unchanged.
- R4: A control token goes out as parity, then a flag of 1, then a 2-bit code, least significant bit first. The codes are 00 flow control, 01 end of packet, 10 error end of packet and 11 escape.
- R5: The parity bit makes the ones count odd. The count covers the parity bit, the previous token's data or code bits, and the current token's flag. Before the first token, the previous bits count as all zero.
- R6: When no token is offered at a token boundary, the block sends an escape token followed directly by a flow-control token. Nothing else can be inserted between these two.
- R7: A pulse on `cfg_wr` loads `cfg_div`, and every bit then lasts that many clock cycles. A written value of 0 acts as 1.
- R8: A new divider, or a new power-save setting, takes effect only at a token boundary. Every bit of one token lasts the same number of cycles.
- R9: With `cfg_psave` at 1, both tokens of a Null go out at the default divider of 20. Data and user control tokens still use the programmed divider. With `cfg_psave` at 0, all tokens use the programmed divider.
- R10: `in_ready` is high for one cycle at a token boundary where no Null is part way through. A token is taken only when `in_valid` and `in_ready` are both high, and each transfer is sent exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz bit-base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the divider |
| cfg_div | input | 8 | Divider value, in clock cycles per bit |
| cfg_psave | input | 1 | Power-save enable for Null tokens |
| in_valid | input | 1 | A token is offered |
| in_is_ctrl | input | 1 | 1: control token, 0: data token |
| in_data | input | 8 | Data byte; bits 1:0 hold the code for a control token |
| in_ready | output | 1 | The offered token is taken this cycle |
| link_d | output | 1 | Serial data line |
| link_s | output | 1 | Serial strobe line |

## Verification
The assertions assume that `cfg_wr` and `in_valid` change only between clock edges. They also assume that a control token offered at the input never carries the escape or flow-control code, since those two codes belong to Nulls. The stimulus drives every input on the falling clock edge and offers only end-of-packet and error-end-of-packet codes as control tokens. It keeps an offered token steady until the token is taken. Each time it changes the divider or power-save, it skips the rate check for three tokens, so tokens already under way are not measured against the new setting.

// File: rtl/dslink_pkg.sv
package dslink_pkg;

    typedef enum logic [1:0] {
        CODE_FCT = 2'b00,
        CODE_EOP = 2'b01,
        CODE_EEP = 2'b10,
        CODE_ESC = 2'b11
    } ctrl_code_e;

    localparam int FRAME_W = 10;

    typedef struct packed {
        logic       is_ctrl;
        logic [7:0] payload;
    } token_t;

    function automatic logic [3:0] len_of(token_t t);
        return t.is_ctrl ? 4'd4 : 4'd10;
    endfunction

    function automatic logic payload_par(token_t t);
        return t.is_ctrl ? ^t.payload[1:0] : ^t.payload;
    endfunction

    // frame bit 0 leaves first: parity, flag, then payload LSB first
    function automatic logic [FRAME_W-1:0] frame_of(token_t t, logic prev_par);
        logic par;
        par = ~(prev_par ^ t.is_ctrl);
        if (t.is_ctrl)
            return {6'b0, t.payload[1:0], t.is_ctrl, par};
        return {t.payload, t.is_ctrl, par};
    endfunction

endpackage

// File: rtl/dslink_rate.sv
module dslink_rate #(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             psave,
    input  logic             boundary,
    input  logic             sel_null,
    output logic             tick
);
    localparam logic [DIV_W-1:0] DEF_V = DIV_W'(DEF_DIV);
    localparam logic [DIV_W-1:0] ONE_V = DIV_W'(1);

    logic [DIV_W-1:0] div_reg, div_act, cnt, next_div;

    assign tick     = (cnt == '0);
    assign next_div = (psave && sel_null) ? DEF_V : div_reg;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_reg <= DEF_V;
            div_act <= DEF_V;
            cnt     <= '0;
        end else begin
            if (cfg_wr)
                div_reg <= (cfg_div == '0) ? ONE_V : cfg_div;
            if (tick) begin
                if (boundary) begin
                    div_act <= next_div;
                    cnt     <= next_div - ONE_V;
                end else begin
                    cnt     <= div_act - ONE_V;
                end
            end else begin
                cnt <= cnt - ONE_V;
            end
        end
    end
endmodule

// File: rtl/dslink_tokgen.sv
module dslink_tokgen
    import dslink_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       in_valid,
    input  logic       in_is_ctrl,
    input  logic [7:0] in_data,
    output logic       in_ready,
    output logic       boundary,
    output logic       sel_null,
    output logic       bit_val
);
    logic [FRAME_W-1:0] sh, frame;
    logic [3:0]         left;
    logic               null_pend, par_acc, take;
    token_t             cur;

    assign boundary = (left == 4'd0);
    assign take     = tick && boundary;
    assign sel_null = null_pend || !in_valid;
    assign in_ready = take && !null_pend;

    always_comb begin
        if (null_pend)
            cur = '{is_ctrl: 1'b1, payload: {6'b0, CODE_FCT}};
        else if (in_valid)
            cur = '{is_ctrl: in_is_ctrl,
                    payload: in_is_ctrl ? {6'b0, in_data[1:0]} : in_data};
        else
            cur = '{is_ctrl: 1'b1, payload: {6'b0, CODE_ESC}};
        frame = frame_of(cur, par_acc);
    end

    assign bit_val = take ? frame[0] : sh[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '0;
            left      <= 4'd0;
            null_pend <= 1'b0;
            par_acc   <= 1'b0;
        end else if (take) begin
            sh        <= frame >> 1;
            left      <= len_of(cur) - 4'd1;
            par_acc   <= payload_par(cur);
            null_pend <= !null_pend && !in_valid;
        end else if (tick) begin
            sh   <= sh >> 1;
            left <= left - 4'd1;
        end
    end
endmodule

// File: rtl/dslink_dsenc.sv
module dslink_dsenc (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_val,
    output logic link_d,
    output logic link_s
);
    always_ff @(posedge clk) begin
        if (rst) begin
            link_d <= 1'b0;
            link_s <= 1'b0;
        end else if (bit_vld) begin
            link_d <= bit_val;
            if (bit_val == link_d)
                link_s <= ~link_s;
        end
    end
endmodule

// File: rtl/dslink_tx.sv
module dslink_tx #(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_psave,
    input  logic             in_valid,
    input  logic             in_is_ctrl,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             link_d,
    output logic             link_s
);
    logic bit_tick, boundary, sel_null, bit_val;

    dslink_rate #(.DIV_W(DIV_W), .DEF_DIV(DEF_DIV)) u_rate (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
        .psave(cfg_psave), .boundary(boundary), .sel_null(sel_null),
        .tick(bit_tick)
    );

    dslink_tokgen u_tok (
        .clk(clk), .rst(rst), .tick(bit_tick), .in_valid(in_valid),
        .in_is_ctrl(in_is_ctrl), .in_data(in_data), .in_ready(in_ready),
        .boundary(boundary), .sel_null(sel_null), .bit_val(bit_val)
    );

    dslink_dsenc u_enc (
        .clk(clk), .rst(rst), .bit_vld(bit_tick), .bit_val(bit_val),
        .link_d(link_d), .link_s(link_s)
    );
endmodule

// File: rtl/dslink_tx_chk.sv
module dslink_tx_chk (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic link_d,
    input logic link_s,
    input logic bit_tick
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!link_d && !link_s));

    // R2
    ds_one_change_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({link_d ^ $past(link_d), link_s ^ $past(link_s)}) <= 1);

    // R7
    bit_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |=> (!$stable(link_d) || !$stable(link_s)));

    // R8
    no_mid_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> ($stable(link_d) && $stable(link_s)));

    // R10
    ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);
endmodule

bind dslink_tx dslink_tx_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready),
    .link_d(link_d), .link_s(link_s), .bit_tick(bit_tick)
);

// File: tb/dslink_tx_bench.sv
module dslink_tx_bench;
    logic       clk = 1'b0, rst = 1'b1;
    logic       cfg_wr = 1'b0, cfg_psave = 1'b0;
    logic [7:0] cfg_div = 8'd0;
    logic       in_valid = 1'b0, in_is_ctrl = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic       in_ready, link_d, link_s;

    always #2.5 clk = ~clk;

    dslink_tx u_dslink_tx (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_div(cfg_div),
        .cfg_psave(cfg_psave), .in_valid(in_valid), .in_is_ctrl(in_is_ctrl),
        .in_data(in_data), .in_ready(in_ready), .link_d(link_d), .link_s(link_s)
    );

    int checks = 0, fails = 0;
    int exp_div = 20;
    bit exp_ps = 1'b0, chk_rate = 1'b1, done = 1'b0;
    int tok_count = 0;
    logic [8:0] q[$];

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: decode the line and score against the queue
    int cyc = 0, last_t = 0, bit_idx = 0, tlen = 10, ivl0 = 0;
    bit mism = 1'b0, after_esc = 1'b0, prev_x = 1'b0;
    logic pd = 1'b0, ps = 1'b0;
    logic [9:0] tb_bits;

    task automatic finish_token();
        logic flag, isnull;
        logic [7:0] pay;
        int ediv;
        logic [8:0] e;
        flag = tb_bits[1];
        pay  = flag ? {6'b0, tb_bits[3:2]} : tb_bits[9:2];
        check(tb_bits[0] == ~(prev_x ^ flag), "R5 parity", tb_bits[0], ~(prev_x ^ flag));
        prev_x = ^pay;
        isnull = flag && (pay[1:0] == 2'b11 || pay[1:0] == 2'b00);
        if (after_esc)
            check(flag && pay[1:0] == 2'b00, "R6 escape then flow control", {flag, pay}, 9'h100);
        else if (flag && pay[1:0] == 2'b00)
            check(1'b0, "R6 lone flow control", {flag, pay}, 9'h103);
        after_esc = flag && pay[1:0] == 2'b11;
        ediv = (isnull && exp_ps) ? 20 : exp_div;
        if (chk_rate) begin
            check(ivl0 == ediv, isnull ? "R9 null rate" : "R7 token rate", ivl0, ediv);
            check(!mism, "R8 uniform bit time", mism, 0);
        end
        if (!isnull) begin
            if (q.size() == 0) check(1'b0, "R10 unexpected token", {flag, pay}, 0);
            else begin
                e = q.pop_front();
                check({flag, pay} == e, flag ? "R4 control token" : "R3 data token", {flag, pay}, e);
            end
        end
        tok_count++;
    endtask

    always @(negedge clk) begin
        if (rst) begin
            check(!link_d && !link_s, "R1 reset lines", {link_d, link_s}, 0);
            last_t = cyc;
        end else if (!done) begin
            cyc++;
            if (link_d != pd || link_s != ps) begin
                check(!(link_d != pd && link_s != ps), "R2 one line per bit", {link_d, link_s}, {pd, ps});
                if (bit_idx == 1) ivl0 = cyc - last_t;
                else if (bit_idx > 1 && (cyc - last_t) != ivl0) mism = 1'b1;
                last_t = cyc;
                tb_bits[bit_idx] = link_d;
                if (bit_idx == 1) tlen = link_d ? 4 : 10;
                bit_idx++;
                if (bit_idx == tlen) begin
                    finish_token();
                    bit_idx = 0; tlen = 10; mism = 1'b0;
                end
            end
            pd = link_d; ps = link_s;
        end
    end

    task automatic wait_tokens(int n);
        int t0 = tok_count;
        while (tok_count < t0 + n) @(negedge clk);
    endtask

    task automatic send(bit c, logic [7:0] v);
        q.push_back({c, v});
        @(negedge clk);
        in_valid = 1'b1; in_is_ctrl = c; in_data = v;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic set_cfg(logic [7:0] d, bit p, int ediv);
        chk_rate = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_div = d; cfg_psave = p;
        @(negedge clk);
        cfg_wr = 1'b0;
        exp_div = ediv; exp_ps = p;
        wait_tokens(3);
        chk_rate = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 default rate on nulls and data
        wait_tokens(4);
        send(1'b0, 8'hA5);
        send(1'b0, 8'h3C);
        wait_tokens(2);
        // R7 fast rate, R4 control codes, back-to-back burst
        set_cfg(8'd4, 1'b0, 4);
        send(1'b0, 8'h01); send(1'b1, 8'h01); send(1'b0, 8'hFF);
        send(1'b1, 8'h02); send(1'b0, 8'h80);
        wait_tokens(4);
        // R9 power-save: nulls at 20, data at 4
        set_cfg(8'd4, 1'b1, 4);
        send(1'b0, 8'h5A); send(1'b0, 8'hC3);
        wait_tokens(4);
        send(1'b1, 8'h01);
        wait_tokens(4);
        // ladder steps
        set_cfg(8'd40, 1'b0, 40);  send(1'b0, 8'h96);
        set_cfg(8'd80, 1'b0, 80);  send(1'b0, 8'h69);
        set_cfg(8'd160, 1'b0, 160); send(1'b0, 8'h0F);
        set_cfg(8'd1, 1'b0, 1);
        for (int i = 0; i < 6; i++) send(1'b0, 8'(i * 37 + 5));
        wait_tokens(4);
        // R7 zero acts as one
        set_cfg(8'd0, 1'b0, 1);
        send(1'b0, 8'hE7); send(1'b1, 8'h02);
        wait_tokens(4);
        // R9 slow programmed rate with power-save
        set_cfg(8'd160, 1'b1, 160);
        send(1'b0, 8'h42);
        wait_tokens(4);
        check(q.size() == 0, "R10 all transfers sent", q.size(), 0);
        check(tok_count > 40, "R6 tokens observed", tok_count, 41);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule